// File: doc/BRIEF.md
# Four-Channel Time-Multiplexed FIR Filter Engine

This block filters four independent 8-bit sample streams with a direct-form FIR response and no feedback path. Each channel owns a single multiplier and a single adder. It spends one fast-clock cycle per tap, so a filter of N taps takes N fast cycles after every sample strobe. The sample period is expected to hold several hundred fast cycles, so the tap loop finishes long before the next sample arrives. When a strobe reaches an enabled channel, the channel shifts the new sample into its private delay line. It then clears its accumulator and sums the products in order: coefficient 0 times the newest sample first, then coefficient 1 times the sample before it, and so on. The channel presents the sum for one cycle with a valid pulse. It then raises a clock-gate request that stays high until the next sample restarts it.

Each channel has its own enable line and its own tap-length select. Full length is 30 taps. Half length is 15 taps and costs less energy for a coarser response. Coefficients are loaded through a small write port that takes a channel number, a tap number and a byte of data. The port accepts a write only while the addressed channel is switched off, so a filter can never be reprogrammed in the middle of a sum. The accumulator is 21 bits wide, which holds the worst-case sum of 30 signed 8x8 products.

Top module: `fir_mac_array`

## Requirements
- R1: After a cycle with `rst_n` low, every channel has `result_valid` 0, `overrun` 0, `gate_req` 1 and `result` 0. All delay-line entries and all coefficients are zero.
- R2: A strobe shifts the channel's 8-bit two's-complement lane of `sample_in` (channel c uses bits c*8+7..c*8) into that channel's delay line only while `ch_enable[c]` is 1. A disabled channel ignores the strobe: its delay line does not move and it produces no result.
- R3: The result is the signed sum of b[k]·x[n-k] for k from 0 to N-1, where x[n] is the newest sample. It is presented as a 21-bit two's-complement value in bits c*21+20..c*21 of `result`, and it holds until the next result or reset.
- R4: With `ch_half[c]`=0 at the strobe, N is 30; with `ch_half[c]`=1, N is 15. `result_valid[c]` is high for exactly one cycle, N clock edges after the edge that took the strobe.
- R5: `gate_req[c]` is 0 from the edge that takes a strobe until the cycle after the valid pulse. It is 1 at all other times, including every cycle after an edge where the channel was disabled.
- R6: If a strobe reaches an enabled channel while its sum is still running, including in the cycle of its final tap, `overrun[c]` pulses for one cycle. The unfinished sum is discarded with no valid pulse, and the new sample starts a fresh sum.
- R7: A coefficient write stores `cfg_data` at tap `cfg_tap` of channel `cfg_ch` only when `ch_enable[cfg_ch]` is 0 and `cfg_tap` is below 30. Otherwise the write is dropped.
- R8: The four channels run independently. The timing and value of one channel's result do not depend on another channel's enable, mode, coefficients or samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_stb | input | 1 | Sample-period strobe, one cycle wide |
| sample_in | input | 32 | Four packed signed 8-bit samples, channel 0 in the low byte |
| ch_enable | input | 4 | Per-channel run enable |
| ch_half | input | 4 | Per-channel tap length, 1 selects 15 taps, 0 selects 30 |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_ch | input | 2 | Channel addressed by the write |
| cfg_tap | input | 5 | Tap addressed by the write, 0 to 29 |
| cfg_data | input | 8 | Signed coefficient value |
| result | output | 84 | Four packed signed 21-bit sums, channel 0 in the low bits |
| result_valid | output | 4 | One-cycle pulse per channel when its sum is ready |
| gate_req | output | 4 | Per-channel request to stop the channel clock |
| overrun | output | 4 | One-cycle pulse when a strobe cut a running sum short |

## Verification
The two functions that can meet in one cycle are the completion of the final tap and the arrival of the next sample strobe. The bench provokes this by issuing strobes exactly N cycles apart in both full and half mode. In that case the final-tap edge and the strobe edge are the same edge. The expected outcome there is an overrun pulse with no valid pulse, and the new sum then completes normally. Strobes spaced N+1 cycles apart are used as the control case, where every sum must complete. A behavioural model built from queues of past samples predicts every output of every channel and is compared with the design each cycle.

// File: rtl/fir_mac_pkg.sv
// Shared types for the time-multiplexed FIR engine.
// Assumes: one package per code base scope, no parameters here.
package fir_mac_pkg;

    typedef enum logic [0:0] {
        CH_IDLE = 1'b0,
        CH_RUN  = 1'b1
    } ch_state_t;

endpackage

// File: rtl/fir_delay_line.sv
// Per-channel sample history. Entry 0 holds the newest sample and entry
// k holds the sample taken k strobes earlier. A read port picks one entry.
// Assumes: shift is already qualified by the channel enable.
module fir_delay_line #(
    parameter int DEPTH  = 30,
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift,
    input  logic signed [DATA_W-1:0] din,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [DATA_W-1:0] rd_data
);

    logic signed [DATA_W-1:0] line_q [DEPTH];

    // Move every entry one place older and load the new sample at entry 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) line_q[k] <= '0;
        end else if (shift) begin
            line_q[0] <= din;
            for (int k = 1; k < DEPTH; k++) line_q[k] <= line_q[k-1];
        end
    end

    // Select the entry for the current tap; out-of-range indices read zero
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = line_q[k];
        end
    end

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_hold_chk
            AST_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                !shift |=> line_q[g] == $past(line_q[g]))
                else $error("delay entry moved without strobe"); // R2
        end
    endgenerate

    AST_LINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        shift |=> line_q[0] == $past(din))
        else $error("new sample not captured"); // R2

endmodule

// File: rtl/fir_coef_bank.sv
// Coefficient store for one channel. Writes are dropped while the channel
// runs (lock high) or when the tap number is beyond the filter length.
// Assumes: wr_en is already decoded for this channel.
module fir_coef_bank #(
    parameter int TAPS   = 30,
    parameter int COEF_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lock,
    input  logic                     wr_en,
    input  logic [IDX_W-1:0]         wr_idx,
    input  logic signed [COEF_W-1:0] wr_data,
    input  logic [IDX_W-1:0]         rd_idx,
    output logic signed [COEF_W-1:0] rd_data
);

    localparam logic [IDX_W-1:0] TAP_LIMIT = IDX_W'(TAPS);

    logic signed [COEF_W-1:0] coef_q [TAPS];
    logic                     wr_ok;

    // A write counts only when unlocked and aimed at a real tap
    assign wr_ok = wr_en && !lock && (wr_idx < TAP_LIMIT);

    // Store accepted writes; reset clears every coefficient
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < TAPS; k++) coef_q[k] <= '0;
        end else if (wr_ok) begin
            for (int k = 0; k < TAPS; k++) begin
                if (wr_idx == IDX_W'(k)) coef_q[k] <= wr_data;
            end
        end
    end

    // Select the coefficient for the current tap
    always_comb begin
        rd_data = '0;
        for (int k = 0; k < TAPS; k++) begin
            if (rd_idx == IDX_W'(k)) rd_data = coef_q[k];
        end
    end

    generate
        for (genvar g = 0; g < TAPS; g++) begin : g_lock_chk
            AST_COEF_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
                lock |=> coef_q[g] == $past(coef_q[g]))
                else $error("coefficient changed while channel enabled"); // R7
        end
    endgenerate

endmodule

// File: rtl/fir_mac_channel.sv
// One filter channel: delay line, coefficient bank and a single
// multiply-accumulate stage that evaluates one tap per clock.
// Assumes: strobes are normally spaced further apart than the tap count.
module fir_mac_channel
    import fir_mac_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int COEF_W    = 8,
    parameter int TAPS_FULL = 30,
    parameter int TAPS_HALF = 15,
    parameter int IDX_W     = 5,
    parameter int ACC_W     = 21
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enable,
    input  logic                     half_mode,
    input  logic                     stb,
    input  logic signed [DATA_W-1:0] sample,
    input  logic                     cfg_wr,
    input  logic [IDX_W-1:0]         cfg_tap,
    input  logic signed [COEF_W-1:0] cfg_data,
    output logic [ACC_W-1:0]         result,
    output logic                     result_valid,
    output logic                     gate_req,
    output logic                     overrun
);

    localparam int PROD_W = DATA_W + COEF_W;
    localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(TAPS_FULL - 1);
    localparam logic [IDX_W-1:0] LAST_HALF = IDX_W'(TAPS_HALF - 1);

    ch_state_t                state_q;
    logic [IDX_W-1:0]         tap_q;
    logic                     half_q;
    logic signed [ACC_W-1:0]  acc_q;
    logic signed [ACC_W-1:0]  res_q;
    logic                     valid_q;
    logic                     ovr_q;
    logic signed [DATA_W-1:0] x_rd;
    logic signed [COEF_W-1:0] c_rd;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  sum_next;
    logic [IDX_W-1:0]         last_tap;
    logic                     take;

    assign take = enable && stb;

    fir_delay_line #(
        .DEPTH (TAPS_FULL),
        .DATA_W(DATA_W),
        .IDX_W (IDX_W)
    ) u_line (
        .clk    (clk),
        .rst_n  (rst_n),
        .shift  (take),
        .din    (sample),
        .rd_idx (tap_q),
        .rd_data(x_rd)
    );

    fir_coef_bank #(
        .TAPS  (TAPS_FULL),
        .COEF_W(COEF_W),
        .IDX_W (IDX_W)
    ) u_coef (
        .clk    (clk),
        .rst_n  (rst_n),
        .lock   (enable),
        .wr_en  (cfg_wr),
        .wr_idx (cfg_tap),
        .wr_data(cfg_data),
        .rd_idx (tap_q),
        .rd_data(c_rd)
    );

    // Single multiplier and adder shared by all taps
    always_comb begin
        prod     = x_rd * c_rd;
        sum_next = acc_q + ACC_W'(prod);
        last_tap = half_q ? LAST_HALF : LAST_FULL;
    end

    // Channel sequencing: restart on strobe, one tap per cycle, publish at the end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= CH_IDLE;
            tap_q   <= '0;
            half_q  <= 1'b0;
            acc_q   <= '0;
            res_q   <= '0;
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (!enable) begin
            state_q <= CH_IDLE;
            tap_q   <= '0;
            valid_q <= 1'b0;
            ovr_q   <= 1'b0;
        end else if (stb) begin
            ovr_q   <= (state_q == CH_RUN);
            state_q <= CH_RUN;
            tap_q   <= '0;
            half_q  <= half_mode;
            acc_q   <= '0;
            valid_q <= 1'b0;
        end else if (state_q == CH_RUN) begin
            ovr_q <= 1'b0;
            if (tap_q == last_tap) begin
                res_q   <= sum_next;
                valid_q <= 1'b1;
                state_q <= CH_IDLE;
                tap_q   <= '0;
            end else begin
                acc_q   <= sum_next;
                tap_q   <= tap_q + 1'b1;
                valid_q <= 1'b0;
            end
        end else begin
            ovr_q   <= 1'b0;
            valid_q <= 1'b0;
        end
    end

    // Outputs: clock may stop once idle and the result has been shown
    assign result       = res_q;
    assign result_valid = valid_q;
    assign overrun      = ovr_q;
    assign gate_req     = (state_q == CH_IDLE) && !valid_q;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid)
        else $error("valid longer than one cycle"); // R4

    AST_TAP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_RUN) |-> (tap_q <= last_tap))
        else $error("tap counter beyond filter length"); // R4

    AST_OVR_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !result_valid)
        else $error("overrun and valid together"); // R6

    AST_OFF_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> gate_req)
        else $error("disabled channel not gated"); // R5

    AST_STB_UNGATED: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !gate_req && !result_valid)
        else $error("accepted strobe left channel gated"); // R5

endmodule

// File: rtl/fir_mac_array.sv
// Top of the four-channel FIR engine. Splits packed buses into lanes,
// decodes the coefficient write port and places one channel per lane.
// Assumes: sample_stb is one cycle wide and shared by all channels.
module fir_mac_array #(
    parameter int NUM_CH    = 4,
    parameter int DATA_W    = 8,
    parameter int COEF_W    = 8,
    parameter int TAPS_FULL = 30,
    parameter int TAPS_HALF = 15,
    localparam int CH_W     = $clog2(NUM_CH),
    localparam int IDX_W    = $clog2(TAPS_FULL),
    localparam int ACC_W    = DATA_W + COEF_W + $clog2(TAPS_FULL)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sample_stb,
    input  logic [NUM_CH*DATA_W-1:0]   sample_in,
    input  logic [NUM_CH-1:0]          ch_enable,
    input  logic [NUM_CH-1:0]          ch_half,
    input  logic                       cfg_we,
    input  logic [CH_W-1:0]            cfg_ch,
    input  logic [IDX_W-1:0]           cfg_tap,
    input  logic [COEF_W-1:0]          cfg_data,
    output logic [NUM_CH*ACC_W-1:0]    result,
    output logic [NUM_CH-1:0]          result_valid,
    output logic [NUM_CH-1:0]          gate_req,
    output logic [NUM_CH-1:0]          overrun
);

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
            logic wr_sel;

            // Route the shared write port to this channel only
            assign wr_sel = cfg_we && (cfg_ch == CH_W'(c));

            fir_mac_channel #(
                .DATA_W   (DATA_W),
                .COEF_W   (COEF_W),
                .TAPS_FULL(TAPS_FULL),
                .TAPS_HALF(TAPS_HALF),
                .IDX_W    (IDX_W),
                .ACC_W    (ACC_W)
            ) u_chan (
                .clk         (clk),
                .rst_n       (rst_n),
                .enable      (ch_enable[c]),
                .half_mode   (ch_half[c]),
                .stb         (sample_stb),
                .sample      (sample_in[c*DATA_W +: DATA_W]),
                .cfg_wr      (wr_sel),
                .cfg_tap     (cfg_tap),
                .cfg_data    (cfg_data),
                .result      (result[c*ACC_W +: ACC_W]),
                .result_valid(result_valid[c]),
                .gate_req    (gate_req[c]),
                .overrun     (overrun[c])
            );
        end
    endgenerate

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (gate_req == '1) && (result_valid == '0) && (overrun == '0))
        else $error("outputs not at reset values"); // R1

endmodule

// File: tb/fir_mac_array_bench.sv
// Bench: behavioural model with sample histories, compared every cycle.
module fir_mac_array_bench;

    localparam int CLK_P = 10;
    localparam int NCH   = 4;
    localparam int NT    = 30;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_stb = 1'b0;
    logic [31:0] sample_in = '0;
    logic [3:0]  ch_enable = '0;
    logic [3:0]  ch_half = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_ch = '0;
    logic [4:0]  cfg_tap = '0;
    logic [7:0]  cfg_data = '0;
    logic [83:0] result;
    logic [3:0]  result_valid;
    logic [3:0]  gate_req;
    logic [3:0]  overrun;

    int checks = 0;
    int errors = 0;
    string phase = "R1";

    fir_mac_array u_fir_mac_array (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .sample_in(sample_in),
        .ch_enable(ch_enable), .ch_half(ch_half), .cfg_we(cfg_we), .cfg_ch(cfg_ch),
        .cfg_tap(cfg_tap), .cfg_data(cfg_data), .result(result),
        .result_valid(result_valid), .gate_req(gate_req), .overrun(overrun)
    );

    always #(CLK_P/2) clk = ~clk;

    // Reference model state
    int m_hist [NCH][$];
    int m_coef [NCH][NT];
    int m_busy [NCH];
    int m_pend [NCH];
    int m_res  [NCH];
    bit m_val  [NCH];
    bit m_ovr  [NCH];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_hist[c] = {};
                for (int k = 0; k < NT; k++) begin
                    m_hist[c].push_back(0);
                    m_coef[c][k] = 0;
                end
                m_busy[c] = 0; m_pend[c] = 0; m_res[c] = 0;
                m_val[c] = 0; m_ovr[c] = 0;
            end
        end else begin
            for (int c = 0; c < NCH; c++) begin
                if (cfg_we && cfg_ch == c && !ch_enable[c] && cfg_tap < NT)
                    m_coef[c][cfg_tap] = int'($signed(cfg_data));
                if (!ch_enable[c]) begin
                    m_busy[c] = 0; m_val[c] = 0; m_ovr[c] = 0;
                end else if (sample_stb) begin
                    int n;
                    m_ovr[c] = (m_busy[c] > 0);
                    m_hist[c].push_front(int'($signed(sample_in[c*8 +: 8])));
                    void'(m_hist[c].pop_back());
                    n = ch_half[c] ? 15 : 30;
                    m_pend[c] = 0;
                    for (int k = 0; k < n; k++) m_pend[c] += m_coef[c][k] * m_hist[c][k];
                    m_busy[c] = n;
                    m_val[c] = 0;
                end else if (m_busy[c] > 0) begin
                    m_ovr[c] = 0;
                    m_busy[c]--;
                    m_val[c] = (m_busy[c] == 0);
                    if (m_busy[c] == 0) m_res[c] = m_pend[c];
                end else begin
                    m_ovr[c] = 0; m_val[c] = 0;
                end
            end
        end
    end

    task automatic chk(string req, int c, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s (phase %s) ch%0d actual %0d expected %0d", req, phase, c, act, exp);
        end
    endtask

    task automatic compare();
        for (int c = 0; c < NCH; c++) begin
            chk("R3", c, int'($signed(result[c*21 +: 21])), m_res[c]);
            chk("R4", c, int'(result_valid[c]), int'(m_val[c]));
            chk("R5", c, int'(gate_req[c]), int'(m_busy[c] == 0 && !m_val[c]));
            chk("R6", c, int'(overrun[c]), int'(m_ovr[c]));
        end
    endtask

    task automatic tick(int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            compare();
            sample_stb = 1'b0;
            cfg_we = 1'b0;
        end
    endtask

    task automatic strobe(int s0, int s1, int s2, int s3);
        sample_in = {8'(s3), 8'(s2), 8'(s1), 8'(s0)};
        sample_stb = 1'b1;
        tick(1);
    endtask

    task automatic write_coef(int c, int t, int d);
        cfg_we = 1'b1; cfg_ch = 2'(c); cfg_tap = 5'(t); cfg_data = 8'(d);
        tick(1);
    endtask

    initial begin
        #(CLK_P * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        // R1: reset values at the ports
        for (int c = 0; c < NCH; c++) begin
            chk("R1", c, int'(gate_req[c]), 1);
            chk("R1", c, int'(result_valid[c]), 0);
            chk("R1", c, int'($signed(result[c*21 +: 21])), 0);
        end
        tick(2);

        // R7: program coefficients while disabled; tap 30/31 writes are dropped
        phase = "R7";
        for (int c = 0; c < NCH; c++)
            for (int t = 0; t < NT; t++)
                write_coef(c, t, ((t * 37 + c * 11) % 256) - 128);
        write_coef(0, 30, 99);
        write_coef(1, 31, 99);

        // R3: full-length filters on all channels, varied samples
        phase = "R3";
        ch_enable = 4'hF; ch_half = 4'h0;
        for (int i = 0; i < 40; i++) begin
            strobe((i*13)%256-128, (i*29+7)%256-128, (i%2) ? 127 : -128, i);
            tick(34);
        end

        // R7: writes aimed at enabled channels must not change results
        phase = "R7";
        for (int t = 0; t < NT; t++) write_coef(t % 4, t, 55);
        for (int i = 0; i < 3; i++) begin strobe(5, -6, 7, -8); tick(34); end

        // R4: half length on channels 1 and 3
        phase = "R4";
        ch_half = 4'b1010;
        for (int i = 0; i < 6; i++) begin strobe(100-i, -90+i, 3*i, -127); tick(33); end

        // R2: channel 2 disabled ignores strobes
        phase = "R2";
        ch_enable = 4'b1011;
        for (int i = 0; i < 4; i++) begin strobe(1, 2, 111, 4); tick(33); end
        ch_enable = 4'hF;
        for (int i = 0; i < 2; i++) begin strobe(-3, 9, 20, 1); tick(33); end

        // R6: strobes exactly at the final tap (spacing N) and inside the run
        phase = "R6";
        ch_half = 4'h0;
        for (int i = 0; i < 4; i++) begin strobe(i, -i, 2*i, 9); tick(29); end
        tick(32);
        for (int i = 0; i < 3; i++) begin strobe(10, 20, 30, 40); tick(9); end
        tick(32);
        ch_half = 4'hF;
        for (int i = 0; i < 4; i++) begin strobe(-50, 60, -70, 80); tick(14); end
        tick(20);
        for (int i = 0; i < 3; i++) begin strobe(-1, 1, -2, 2); tick(15); end
        tick(20);

        // R8: mixed modes, enables and extreme magnitude
        phase = "R8";
        ch_enable = 4'h0; tick(1);
        for (int t = 0; t < NT; t++) write_coef(0, t, -128);
        ch_enable = 4'b0101; ch_half = 4'b0100;
        for (int i = 0; i < 31; i++) begin strobe(-128, 77, -5, 66); tick(31); end
        ch_enable = 4'b1101; ch_half = 4'b1000;
        for (int i = 0; i < 4; i++) begin strobe(12, 34, -56, 78); tick(31); end
        ch_enable = 4'b0000; tick(3);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule